// File: doc/BRIEF.md
# Link Training Controller

This block runs the two-phase bring-up of a multi-lane serial display link. On a start pulse it configures the sink (power, spread, lane count, link rate), then runs a clock-recovery loop on training pattern 1. When every active lane has recovered its clock, it runs an equalization loop on pattern 3 if the sink can take it, otherwise on pattern 2. Either way it closes with a finish step that removes the pattern and ends training on the source.

All sink traffic goes through one request/acknowledge command port. Writes carry an address code and a data byte. A status read returns, in the same acknowledge cycle, a per-lane status vector and a per-lane adjustment request vector. Between polls the block waits for programmable microsecond delays, converted to clock cycles through a parameter. Every requested adjustment is merged into a single drive setting, which is applied to the source and written to the sink for all lanes at once. On completion the block pulses done with a pass flag and the final swing and pre-emphasis levels.

Top module: `lt_ctrl`

## Requirements
- R1: After reset, done_o, cmd_req_o, src_training_o and src_pat_o are all zero.
- R2: After start_i the sink writes run in this order. First, POWER (address 1) with data 0x01. Then SPREAD (address 2) with 0x10 if cap_spread_i is set, else 0x00. Then LANES (address 3) with the lane count in bits 6:0 and cap_enh_i in bit 7. Then RATE (address 4) with rate_code_i. Then PATTERN (address 5) with 0. src_training_o rises together with that last write.
- R3: Clock recovery first writes PATTERN 1 with src_pat_o at 1, then DRIVE (address 6) with 0x00. It waits at least 400 µs and the recovery delay before the first STATUS (address 7) read. Later reads are at least the recovery delay apart.
- R4: Only lanes below lane_cnt_i count. Each lane has a 3-bit status group: bit 0 means clock recovered, bit 1 means equalized, bit 2 means symbol locked. Clock recovery passes when bit 0 is set on every active lane.
- R5: Each lane has a 4-bit adjustment request: bits 1:0 are swing, bits 3:2 are pre-emphasis. The new drive byte takes the highest active-lane swing in bits 1:0 and the highest pre-emphasis in bits 4:3. Bit 2 is set when swing is 3, and bit 5 is set when pre-emphasis is 3.
- R6: Clock recovery fails when a poll shows no recovery while the current drive already has the max-swing flag set.
- R7: Clock recovery fails once five consecutive polls after the first find the applied swing unchanged from the previous poll. With a constant request this takes 6 reads at swing 0, and 7 reads at any other level.
- R8: Equalization writes PATTERN 3 if cap_tps3_i is set, otherwise PATTERN 2, and src_pat_o carries the same value. It passes when bits 1 and 2 are set on every active lane.
- R9: Equalization fails on the seventh failing poll, which gives 8 status reads in total when recovery passed on the first read.
- R10: A status read acknowledged with cmd_ok_i low fails the training at once. A request is held stable until it is acknowledged.
- R11: After pass or failure the block waits at least 400 µs and writes PATTERN 0. It then drops src_pat_o and src_training_o, and pulses done_o with pass_o, swing_o and preemph_o taken from the last drive setting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start a training run |
| lane_cnt_i | input | LCW | Active lane count (1, 2 or 4) |
| cap_spread_i | input | 1 | Sink supports down-spread |
| cap_enh_i | input | 1 | Sink supports enhanced framing |
| cap_tps3_i | input | 1 | Sink supports pattern 3 |
| rate_code_i | input | 8 | Link-rate code written to the sink |
| cr_wait_us_i | input | US_W | Clock-recovery poll delay in µs |
| eq_wait_us_i | input | US_W | Equalization poll delay in µs |
| cmd_req_o | output | 1 | Command request, held until ack |
| cmd_wr_o | output | 1 | 1 = write, 0 = status read |
| cmd_addr_o | output | 4 | Sink address code |
| cmd_data_o | output | 8 | Write data |
| cmd_ack_i | input | 1 | Command acknowledge |
| cmd_ok_i | input | 1 | Read succeeded (valid with ack) |
| lane_stat_i | input | 3*LANES | Per-lane status groups (valid with ack) |
| lane_adj_i | input | 4*LANES | Per-lane adjustment requests (valid with ack) |
| src_pat_o | output | 2 | Pattern driven by the source (0 = none) |
| src_drive_o | output | 8 | Drive byte applied to all source lanes |
| src_training_o | output | 1 | Source in training mode |
| done_o | output | 1 | One-cycle completion pulse |
| pass_o | output | 1 | Training succeeded (valid with done_o) |
| swing_o | output | 2 | Final swing level |
| preemph_o | output | 2 | Final pre-emphasis level |

## Verification
The sink model answers with scripted status and adjustment sequences, one per scenario. An immediate four-lane recovery followed by one equalization adjustment confirms the full write order and the poll spacing. A single-lane run drives failing status and maximum requests on the idle lanes, which shows that only active lanes count and that pattern 3 is chosen. A request that reaches swing 3 is told apart from a constant request, because the first aborts after two reads and the second after six or seven depending on the level. An equalization loop that never converges, and a status read that returns an error, show the other two failure exits, each ending with the same finish sequence.

// File: rtl/lt_pkg.sv
package lt_pkg;
  typedef enum logic [3:0] {
    ADR_NONE    = 4'd0,
    ADR_POWER   = 4'd1,
    ADR_SPREAD  = 4'd2,
    ADR_LANES   = 4'd3,
    ADR_RATE    = 4'd4,
    ADR_PATTERN = 4'd5,
    ADR_DRIVE   = 4'd6,
    ADR_STATUS  = 4'd7
  } sink_adr_e;

  localparam logic [7:0] PWR_ON      = 8'h01;
  localparam logic [7:0] SPREAD_HALF = 8'h10;

  typedef enum logic [4:0] {
    S_IDLE, S_PWR, S_SPRD, S_LNS, S_RATE, S_PAT_OFF,
    S_CR_PAT, S_CR_DRV0, S_CR_HOLD, S_CR_WAIT, S_CR_RD, S_CR_EVAL, S_CR_DRV,
    S_EQ_PAT, S_EQ_WAIT, S_EQ_RD, S_EQ_EVAL, S_EQ_DRV,
    S_FIN_WAIT, S_FIN_PAT, S_DONE
  } lt_state_e;
endpackage

// File: rtl/lt_wait_timer.sv
module lt_wait_timer #(
  parameter int CYC_PER_US = 100,
  parameter int UW         = 9,
  parameter int TW         = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic [UW-1:0] us_i,
  output logic          zero_o
);
  logic [TW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)               cnt_q <= '0;
    else if (load_i)           cnt_q <= TW'(us_i) * TW'(CYC_PER_US);
    else if (cnt_q != '0)      cnt_q <= cnt_q - 1'b1;
  end

  assign zero_o = (cnt_q == '0);

  // R3
  tick_down_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_q != '0 && !load_i) |=> (cnt_q == $past(cnt_q) - 1'b1));
endmodule

// File: rtl/lt_drive_merge.sv
module lt_drive_merge #(
  parameter int LANES = 4,
  parameter int LCW   = 3
) (
  input  logic [4*LANES-1:0] adj_i,
  input  logic [LCW-1:0]     lanes_i,
  output logic [7:0]         drive_o
);
  logic [1:0] sw, pe;

  always_comb begin
    sw = 2'd0;
    pe = 2'd0;
    for (int i = 0; i < LANES; i++) begin
      if (LCW'(i) < lanes_i) begin
        if (adj_i[4*i +: 2] > sw)   sw = adj_i[4*i +: 2];
        if (adj_i[4*i+2 +: 2] > pe) pe = adj_i[4*i+2 +: 2];
      end
    end
    drive_o = {2'b00, pe == 2'd3, pe, sw == 2'd3, sw};
  end
endmodule

// File: rtl/lt_lane_eval.sv
module lt_lane_eval #(
  parameter int LANES = 4,
  parameter int LCW   = 3
) (
  input  logic [3*LANES-1:0] stat_i,
  input  logic [LCW-1:0]     lanes_i,
  output logic               cr_all_o,
  output logic               eq_all_o
);
  logic [LANES-1:0] cr_ok, eq_ok;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic act;
    assign act      = LCW'(g) < lanes_i;
    assign cr_ok[g] = !act || stat_i[3*g];
    assign eq_ok[g] = !act || (stat_i[3*g+1] && stat_i[3*g+2]);
  end

  assign cr_all_o = &cr_ok;
  assign eq_all_o = &eq_ok;
endmodule

// File: rtl/lt_ctrl.sv
module lt_ctrl
  import lt_pkg::*;
#(
  parameter int LANES      = 4,
  parameter int CYC_PER_US = 100,
  parameter int US_W       = 8,
  parameter int HOLD_US    = 400,
  parameter int CR_LIMIT   = 5,
  parameter int EQ_LIMIT   = 5,
  localparam int LCW    = $clog2(LANES + 1),
  localparam int MAX_US = (HOLD_US > (1 << US_W) - 1) ? HOLD_US : (1 << US_W) - 1,
  localparam int UW     = $clog2(MAX_US + 1),
  localparam int TW     = $clog2(MAX_US * CYC_PER_US + 1)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               start_i,
  input  logic [LCW-1:0]     lane_cnt_i,
  input  logic               cap_spread_i,
  input  logic               cap_enh_i,
  input  logic               cap_tps3_i,
  input  logic [7:0]         rate_code_i,
  input  logic [US_W-1:0]    cr_wait_us_i,
  input  logic [US_W-1:0]    eq_wait_us_i,
  output logic               cmd_req_o,
  output logic               cmd_wr_o,
  output logic [3:0]         cmd_addr_o,
  output logic [7:0]         cmd_data_o,
  input  logic               cmd_ack_i,
  input  logic               cmd_ok_i,
  input  logic [3*LANES-1:0] lane_stat_i,
  input  logic [4*LANES-1:0] lane_adj_i,
  output logic [1:0]         src_pat_o,
  output logic [7:0]         src_drive_o,
  output logic               src_training_o,
  output logic               done_o,
  output logic               pass_o,
  output logic [1:0]         swing_o,
  output logic [1:0]         preemph_o
);
  lt_state_e state_q, state_d;
  logic [3*LANES-1:0] stat_q;
  logic [4*LANES-1:0] adj_q;
  logic [7:0] drive_q, drive_new;
  logic [1:0] pat_q, prev_sw_q;
  logic [2:0] tries_q;
  logic prev_vld_q, train_q, pass_q;
  logic cr_all, eq_all, tmr_zero, tmr_load, rep_hit, cr_stall;
  logic [UW-1:0] tmr_us;
  logic is_wr, is_rd;

  lt_wait_timer #(.CYC_PER_US(CYC_PER_US), .UW(UW), .TW(TW)) u_tmr (
    .clk_i, .rst_ni, .load_i(tmr_load), .us_i(tmr_us), .zero_o(tmr_zero));

  lt_drive_merge #(.LANES(LANES), .LCW(LCW)) u_merge (
    .adj_i(adj_q), .lanes_i(lane_cnt_i), .drive_o(drive_new));

  lt_lane_eval #(.LANES(LANES), .LCW(LCW)) u_eval (
    .stat_i(stat_q), .lanes_i(lane_cnt_i), .cr_all_o(cr_all), .eq_all_o(eq_all));

  assign rep_hit  = prev_vld_q && (prev_sw_q == drive_q[1:0]);
  assign cr_stall = rep_hit && (tries_q == 3'(CR_LIMIT - 1));

  always_comb begin
    state_d  = state_q;
    tmr_load = 1'b0;
    tmr_us   = '0;
    unique case (state_q)
      S_IDLE:    if (start_i) state_d = S_PWR;
      S_PWR:     if (cmd_ack_i) state_d = S_SPRD;
      S_SPRD:    if (cmd_ack_i) state_d = S_LNS;
      S_LNS:     if (cmd_ack_i) state_d = S_RATE;
      S_RATE:    if (cmd_ack_i) state_d = S_PAT_OFF;
      S_PAT_OFF: if (cmd_ack_i) state_d = S_CR_PAT;
      S_CR_PAT:  if (cmd_ack_i) state_d = S_CR_DRV0;
      S_CR_DRV0: if (cmd_ack_i) begin state_d = S_CR_HOLD; tmr_load = 1'b1; tmr_us = UW'(HOLD_US); end
      S_CR_HOLD: if (tmr_zero)  begin state_d = S_CR_WAIT; tmr_load = 1'b1; tmr_us = UW'(cr_wait_us_i); end
      S_CR_WAIT: if (tmr_zero)  state_d = S_CR_RD;
      S_CR_RD:   if (cmd_ack_i) begin
                   if (cmd_ok_i) state_d = S_CR_EVAL;
                   else begin state_d = S_FIN_WAIT; tmr_load = 1'b1; tmr_us = UW'(HOLD_US); end
                 end
      S_CR_EVAL: if (cr_all) state_d = S_EQ_PAT;
                 else if (drive_q[2] || cr_stall) begin
                   state_d = S_FIN_WAIT; tmr_load = 1'b1; tmr_us = UW'(HOLD_US);
                 end else state_d = S_CR_DRV;
      S_CR_DRV:  if (cmd_ack_i) begin state_d = S_CR_WAIT; tmr_load = 1'b1; tmr_us = UW'(cr_wait_us_i); end
      S_EQ_PAT:  if (cmd_ack_i) begin state_d = S_EQ_WAIT; tmr_load = 1'b1; tmr_us = UW'(eq_wait_us_i); end
      S_EQ_WAIT: if (tmr_zero)  state_d = S_EQ_RD;
      S_EQ_RD:   if (cmd_ack_i) begin
                   if (cmd_ok_i) state_d = S_EQ_EVAL;
                   else begin state_d = S_FIN_WAIT; tmr_load = 1'b1; tmr_us = UW'(HOLD_US); end
                 end
      S_EQ_EVAL: if (eq_all || tries_q > 3'(EQ_LIMIT)) begin
                   state_d = S_FIN_WAIT; tmr_load = 1'b1; tmr_us = UW'(HOLD_US);
                 end else state_d = S_EQ_DRV;
      S_EQ_DRV:  if (cmd_ack_i) begin state_d = S_EQ_WAIT; tmr_load = 1'b1; tmr_us = UW'(eq_wait_us_i); end
      S_FIN_WAIT: if (tmr_zero) state_d = S_FIN_PAT;
      S_FIN_PAT: if (cmd_ack_i) state_d = S_DONE;
      S_DONE:    state_d = S_IDLE;
      default:   state_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= S_IDLE;  stat_q <= '0;  adj_q <= '0;  drive_q <= '0;
      pat_q <= '0;  prev_sw_q <= '0;  prev_vld_q <= 1'b0;  tries_q <= '0;
      train_q <= 1'b0;  pass_q <= 1'b0;
    end else begin
      state_q <= state_d;
      unique case (state_q)
        S_IDLE: if (start_i) begin
          pass_q <= 1'b0;  tries_q <= '0;  prev_vld_q <= 1'b0;
        end
        S_RATE: if (cmd_ack_i) train_q <= 1'b1;
        S_PAT_OFF: if (cmd_ack_i) begin pat_q <= 2'd1; drive_q <= '0; end
        S_CR_RD, S_EQ_RD: if (cmd_ack_i) begin stat_q <= lane_stat_i; adj_q <= lane_adj_i; end
        S_CR_EVAL:
          if (cr_all) begin
            pat_q   <= cap_tps3_i ? 2'd3 : 2'd2;
            tries_q <= '0;
          end else if (!drive_q[2] && !cr_stall) begin
            tries_q    <= rep_hit ? tries_q + 3'd1 : 3'd0;
            prev_sw_q  <= drive_q[1:0];
            prev_vld_q <= 1'b1;
            drive_q    <= drive_new;
          end
        S_EQ_EVAL:
          if (eq_all) pass_q <= 1'b1;
          else if (tries_q <= 3'(EQ_LIMIT)) begin
            drive_q <= drive_new;
            tries_q <= tries_q + 3'd1;
          end
        S_FIN_PAT: if (cmd_ack_i) begin pat_q <= 2'd0; train_q <= 1'b0; end
        default: ;
      endcase
    end
  end

  always_comb begin
    is_wr = 1'b1;
    is_rd = 1'b0;
    cmd_addr_o = ADR_NONE;
    cmd_data_o = 8'h00;
    unique case (state_q)
      S_PWR:     begin cmd_addr_o = ADR_POWER;   cmd_data_o = PWR_ON; end
      S_SPRD:    begin cmd_addr_o = ADR_SPREAD;  cmd_data_o = cap_spread_i ? SPREAD_HALF : 8'h00; end
      S_LNS:     begin cmd_addr_o = ADR_LANES;   cmd_data_o = {cap_enh_i, 7'(lane_cnt_i)}; end
      S_RATE:    begin cmd_addr_o = ADR_RATE;    cmd_data_o = rate_code_i; end
      S_PAT_OFF, S_FIN_PAT: cmd_addr_o = ADR_PATTERN;
      S_CR_PAT, S_EQ_PAT:   begin cmd_addr_o = ADR_PATTERN; cmd_data_o = {6'd0, pat_q}; end
      S_CR_DRV0, S_CR_DRV, S_EQ_DRV: begin cmd_addr_o = ADR_DRIVE; cmd_data_o = drive_q; end
      S_CR_RD, S_EQ_RD: begin is_wr = 1'b0; is_rd = 1'b1; cmd_addr_o = ADR_STATUS; end
      default:   is_wr = 1'b0;
    endcase
  end

  assign cmd_req_o      = is_wr || is_rd;
  assign cmd_wr_o       = is_wr;
  assign src_pat_o      = pat_q;
  assign src_drive_o    = drive_q;
  assign src_training_o = train_q;
  assign done_o         = (state_q == S_DONE);
  assign pass_o         = pass_q;
  assign swing_o        = drive_q[1:0];
  assign preemph_o      = drive_q[4:3];

  // R10
  req_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_req_o && !cmd_ack_i) |=> (cmd_req_o && $stable(cmd_addr_o) && $stable(cmd_data_o)));
  // R11
  finish_clean_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (src_pat_o == 2'd0 && !src_training_o));
  // R3
  cr_pattern_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == S_CR_RD) |-> (src_pat_o == 2'd1 && src_training_o));
  // R8
  eq_pattern_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == S_EQ_RD) |-> src_pat_o[1]);
  // R7
  cr_tries_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == S_CR_EVAL) |-> (tries_q < 3'(CR_LIMIT)));
  // R6
  max_swing_abort_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == S_CR_EVAL && !cr_all && drive_q[2]) |=> (state_q == S_FIN_WAIT));
endmodule

// File: tb/lt_ctrl_test.sv
module lt_ctrl_test;
  localparam int LANES = 4;
  localparam int CPU   = 2;
  localparam int HOLD  = 400 * CPU;

  logic clk = 1'b0, rst_n = 1'b0;
  logic start = 1'b0;
  logic [2:0] lane_cnt = 3'd4;
  logic cap_spread = 1'b0, cap_enh = 1'b0, cap_tps3 = 1'b0;
  logic [7:0] rate = 8'h0A;
  logic [7:0] cr_us = 8'd3, eq_us = 8'd5;
  logic cmd_req, cmd_wr, cmd_ack = 1'b0, cmd_ok = 1'b1;
  logic [3:0] cmd_addr;
  logic [7:0] cmd_data;
  logic [3*LANES-1:0] lane_stat = '0;
  logic [4*LANES-1:0] lane_adj = '0;
  logic [1:0] src_pat, swing, preemph;
  logic [7:0] src_drive;
  logic src_training, done, pass;

  lt_ctrl #(.LANES(LANES), .CYC_PER_US(CPU)) uut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .lane_cnt_i(lane_cnt),
    .cap_spread_i(cap_spread), .cap_enh_i(cap_enh), .cap_tps3_i(cap_tps3),
    .rate_code_i(rate), .cr_wait_us_i(cr_us), .eq_wait_us_i(eq_us),
    .cmd_req_o(cmd_req), .cmd_wr_o(cmd_wr), .cmd_addr_o(cmd_addr), .cmd_data_o(cmd_data),
    .cmd_ack_i(cmd_ack), .cmd_ok_i(cmd_ok), .lane_stat_i(lane_stat), .lane_adj_i(lane_adj),
    .src_pat_o(src_pat), .src_drive_o(src_drive), .src_training_o(src_training),
    .done_o(done), .pass_o(pass), .swing_o(swing), .preemph_o(preemph));

  always #2 clk = ~clk;

  int cyc = 0, errors = 0, checks = 0;
  int wr_n = 0, rd_n = 0, resp_n = 1;
  logic [3:0] wr_adr [0:63];
  logic [7:0] wr_dat [0:63];
  int wr_cyc [0:63];
  int rd_cyc [0:63];
  logic [1:0] rd_pat [0:63];
  logic [11:0] r_stat [0:15];
  logic [15:0] r_adj [0:15];
  logic r_ok [0:15];
  logic d_pass, d_trn;
  logic [1:0] d_sw, d_pe, d_pat;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000) begin
      errors++; checks++;
      $display("FAIL R11 watchdog actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  // sink model: acknowledge every request in the cycle it is seen
  initial forever begin
    @(negedge clk);
    cmd_ack = cmd_req;
    if (cmd_req && cmd_wr && wr_n < 64) begin
      wr_adr[wr_n] = cmd_addr; wr_dat[wr_n] = cmd_data; wr_cyc[wr_n] = cyc; wr_n++;
    end else if (cmd_req && !cmd_wr && rd_n < 64) begin
      int k;
      k = (rd_n < resp_n) ? rd_n : resp_n - 1;
      lane_stat = r_stat[k]; lane_adj = r_adj[k]; cmd_ok = r_ok[k];
      rd_cyc[rd_n] = cyc; rd_pat[rd_n] = src_pat; rd_n++;
    end
  end

  task automatic chk(input bit c, input string tag, input int act, input int exp);
    checks++;
    if (!c) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [11:0] st(input logic [2:0] l3, l2, l1, l0);
    return {l3, l2, l1, l0};
  endfunction

  task automatic set_resp(input int idx, input logic [11:0] s, input logic [15:0] a, input logic ok);
    r_stat[idx] = s; r_adj[idx] = a; r_ok[idx] = ok;
    if (idx + 1 > resp_n) resp_n = idx + 1;
  endtask

  task automatic run();
    wr_n = 0; rd_n = 0;
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    while (!done) @(negedge clk);
    d_pass = pass; d_sw = swing; d_pe = preemph; d_pat = src_pat; d_trn = src_training;
    @(negedge clk);
  endtask

  task automatic chk_finish(input string tag);
    chk(d_pat == 2'd0 && !d_trn, {tag, " R11 source idle at done"}, {d_pat, d_trn}, 0);
    chk(wr_adr[wr_n-1] == 4'd5 && wr_dat[wr_n-1] == 8'h00, {tag, " R11 last write pattern off"},
        {wr_adr[wr_n-1], wr_dat[wr_n-1]}, 12'h500);
    chk(wr_cyc[wr_n-1] - rd_cyc[rd_n-1] >= HOLD, {tag, " R11 finish hold"},
        wr_cyc[wr_n-1] - rd_cyc[rd_n-1], HOLD);
  endtask

  task automatic t_reset();
    chk(!done && !cmd_req && !src_training && src_pat == 2'd0, "R1 reset outputs",
        {done, cmd_req, src_training, src_pat}, 0);
  endtask

  task automatic t_four_lane();
    lane_cnt = 3'd4; cap_spread = 1'b1; cap_enh = 1'b1; cap_tps3 = 1'b0; rate = 8'h0A; resp_n = 1;
    set_resp(0, st(3'b001, 3'b001, 3'b001, 3'b001), 16'h0000, 1'b1);
    set_resp(1, st(3'b001, 3'b001, 3'b001, 3'b001), 16'h0600, 1'b1);
    set_resp(2, st(3'b111, 3'b111, 3'b111, 3'b111), 16'h0000, 1'b1);
    run();
    chk(wr_n == 10, "R2 write count", wr_n, 10);
    chk(wr_adr[0] == 4'd1 && wr_dat[0] == 8'h01, "R2 power", {wr_adr[0], wr_dat[0]}, 12'h101);
    chk(wr_adr[1] == 4'd2 && wr_dat[1] == 8'h10, "R2 spread on", {wr_adr[1], wr_dat[1]}, 12'h210);
    chk(wr_adr[2] == 4'd3 && wr_dat[2] == 8'h84, "R2 lanes enh", {wr_adr[2], wr_dat[2]}, 12'h384);
    chk(wr_adr[3] == 4'd4 && wr_dat[3] == 8'h0A, "R2 rate", {wr_adr[3], wr_dat[3]}, 12'h40A);
    chk(wr_adr[4] == 4'd5 && wr_dat[4] == 8'h00, "R2 pattern off", {wr_adr[4], wr_dat[4]}, 12'h500);
    chk(wr_adr[5] == 4'd5 && wr_dat[5] == 8'h01, "R3 pattern 1", {wr_adr[5], wr_dat[5]}, 12'h501);
    chk(wr_adr[6] == 4'd6 && wr_dat[6] == 8'h00, "R3 drive cleared", {wr_adr[6], wr_dat[6]}, 12'h600);
    chk(rd_cyc[0] - wr_cyc[6] >= HOLD + 3 * CPU, "R3 hold before first poll",
        rd_cyc[0] - wr_cyc[6], HOLD + 3 * CPU);
    chk(rd_pat[0] == 2'd1, "R3 source pattern 1", rd_pat[0], 1);
    chk(wr_dat[7] == 8'h02 && rd_pat[1] == 2'd2, "R8 pattern 2", {wr_dat[7], rd_pat[1]}, 12'h022);
    chk(wr_adr[8] == 4'd6 && wr_dat[8] == 8'h0A, "R5 merged drive", {wr_adr[8], wr_dat[8]}, 12'h60A);
    chk(rd_cyc[2] - rd_cyc[1] >= 5 * CPU, "R3 eq poll spacing", rd_cyc[2] - rd_cyc[1], 5 * CPU);
    chk(rd_n == 3 && d_pass && d_sw == 2'd2 && d_pe == 2'd1, "R8 pass result",
        {rd_n[3:0], d_pass, d_sw, d_pe}, {4'd3, 1'b1, 2'd2, 2'd1});
    chk_finish("four-lane");
  endtask

  task automatic t_one_lane();
    lane_cnt = 3'd1; cap_spread = 1'b0; cap_enh = 1'b0; cap_tps3 = 1'b1; resp_n = 1;
    set_resp(0, st(3'b110, 3'b110, 3'b110, 3'b001), 16'hFFF0, 1'b1);
    set_resp(1, st(3'b110, 3'b110, 3'b110, 3'b001), 16'hFFF1, 1'b1);
    set_resp(2, st(3'b000, 3'b000, 3'b000, 3'b111), 16'hFFF0, 1'b1);
    run();
    chk(wr_dat[1] == 8'h00 && wr_dat[2] == 8'h01, "R2 spread off lanes 1",
        {wr_dat[1], wr_dat[2]}, 16'h0001);
    chk(wr_dat[7] == 8'h03 && rd_pat[1] == 2'd3, "R8 pattern 3", {wr_dat[7], rd_pat[1]}, 12'h033);
    chk(wr_dat[8] == 8'h01, "R4 inactive lanes ignored in merge", wr_dat[8], 8'h01);
    chk(rd_n == 3 && d_pass && d_sw == 2'd1 && d_pe == 2'd0, "R4 single lane pass",
        {rd_n[3:0], d_pass, d_sw, d_pe}, {4'd3, 1'b1, 2'd1, 2'd0});
    chk_finish("one-lane");
  endtask

  task automatic t_max_swing();
    lane_cnt = 3'd2; cap_tps3 = 1'b0; resp_n = 1;
    set_resp(0, 12'h000, 16'h0C30, 1'b1);
    run();
    chk(wr_n == 9 && wr_dat[7] == 8'h07, "R5 max swing flag", {wr_n[7:0], wr_dat[7]}, 16'h0907);
    chk(rd_n == 2 && !d_pass && d_sw == 2'd3 && d_pe == 2'd0, "R6 abort at max swing",
        {rd_n[3:0], d_pass, d_sw, d_pe}, {4'd2, 1'b0, 2'd3, 2'd0});
    chk_finish("max-swing");
  endtask

  task automatic t_repeat(input logic [15:0] adj, input int exp_rd, input logic [1:0] exp_sw);
    lane_cnt = 3'd4; resp_n = 1;
    set_resp(0, 12'h000, adj, 1'b1);
    run();
    chk(rd_n == exp_rd && !d_pass && d_sw == exp_sw, "R7 repeat abort",
        {rd_n[3:0], d_pass, d_sw}, {exp_rd[3:0], 1'b0, exp_sw});
    chk(rd_cyc[1] - rd_cyc[0] >= 3 * CPU && rd_cyc[1] - rd_cyc[0] <= 3 * CPU + 8,
        "R3 cr poll spacing", rd_cyc[1] - rd_cyc[0], 3 * CPU);
    chk_finish("repeat");
  endtask

  task automatic t_eq_fail();
    lane_cnt = 3'd4; resp_n = 1;
    set_resp(0, st(3'b001, 3'b001, 3'b001, 3'b001), 16'h0000, 1'b1);
    set_resp(1, st(3'b001, 3'b001, 3'b001, 3'b001), 16'hC000, 1'b1);
    run();
    chk(wr_dat[8] == 8'h38, "R5 max pre-emphasis flag", wr_dat[8], 8'h38);
    chk(rd_n == 8 && !d_pass && d_pe == 2'd3 && d_sw == 2'd0, "R9 eq gives up",
        {rd_n[3:0], d_pass, d_sw, d_pe}, {4'd8, 1'b0, 2'd0, 2'd3});
    chk_finish("eq-fail");
  endtask

  task automatic t_read_err();
    lane_cnt = 3'd4; resp_n = 1;
    set_resp(0, 12'hFFF, 16'h0000, 1'b0);
    run();
    chk(rd_n == 1 && !d_pass && wr_n == 8, "R10 read error fails",
        {rd_n[3:0], d_pass, wr_n[7:0]}, {4'd1, 1'b0, 8'd8});
    chk_finish("read-err");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_four_lane();
    t_one_lane();
    t_max_swing();
    t_repeat(16'h0000, 6, 2'd0);
    t_repeat(16'h1111, 7, 2'd1);
    t_eq_fail();
    t_read_err();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule